// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps every instruction that has been dispatched but not yet retired, in the order it was dispatched, inside a circular store of entries. A head pointer marks the oldest entry and a tail pointer marks the next free slot. A new instruction is written at the tail. Two later events update each entry: the scheduler marks it issued, and execution marks it done. When execution marks an entry done, it also writes the result into the rename register that belongs to that entry.

In each cycle the block looks at the head entry. If that entry is done, the block presents it on the retire write port: the instruction address, the destination architectural register and the value taken from its rename register. The entry then leaves the buffer. Younger instructions can read results that have not yet retired, by rename tag, through a bypass read port. A rollback request names one un-retired entry. That entry and every entry younger than it are discarded, and the next dispatch reuses the slot of the named entry.

Top module: `rob_retire_unit`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o` is 1, `disp_idx_o` is 0 and `ret_valid_o` is 0.
- R2: Each accepted dispatch takes the entry at the tail. `disp_idx_o` shows that index, and it counts up by one per dispatch and wraps from 7 to 0.
- R3: Once all 8 entries hold instructions, `disp_ready_o` is 0. A dispatch attempted in that state changes no entry.
- R4: Only the head entry may retire, and only after it is done. A younger entry that is done waits until every older entry has retired.
- R5: A retiring entry shows on the retire port its instruction address, its destination register and the value last written to its rename register.
- R6: A completion is accepted only for a valid entry whose issued bit is set. Any other completion sets no done bit and writes no rename register.
- R7: The bypass read port returns the value that a completion wrote into a rename register, before the owning entry retires.
- R8: A rollback to a valid entry discards that entry and all younger entries in the same cycle. Completions sent to discarded entries are ignored, and the next dispatch uses the index that was named.
- R9: While `rb_valid_i` is high, no entry retires and `disp_ready_o` is 0. A done head entry retires in the first cycle after the request ends.
- R10: A rollback that names an entry that is not valid changes neither pointer.
- R11: At most one entry retires per cycle. A run of done entries leaves the buffer one per cycle, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_pc_i | input | 32 | Address of the dispatched instruction |
| disp_areg_i | input | 5 | Destination architectural register |
| disp_preg_i | input | 6 | Rename register assigned to the destination |
| disp_ready_o | output | 1 | A dispatch can be accepted this cycle |
| disp_idx_o | output | 3 | Entry index that the next dispatch will take |
| iss_valid_i | input | 1 | Issue mark |
| iss_idx_i | input | 3 | Entry to mark issued |
| cmp_valid_i | input | 1 | Completion mark |
| cmp_idx_i | input | 3 | Entry to mark done |
| cmp_data_i | input | 32 | Result, written to the entry's rename register |
| rd_preg_i | input | 6 | Bypass read tag |
| rd_data_o | output | 32 | Value held in that rename register |
| rb_valid_i | input | 1 | Rollback request |
| rb_idx_i | input | 3 | Oldest entry to discard |
| ret_valid_o | output | 1 | Architectural register write this cycle |
| ret_pc_o | output | 32 | Address of the retiring instruction |
| ret_areg_o | output | 5 | Architectural register being written |
| ret_data_o | output | 32 | Value being written |

## Verification
The bench completes entries out of order, with the youngest first. A design that retired whichever entry finished first would put a younger result into the register file too early. It completes an entry that was never issued, and it completes an entry that a rollback has just discarded. A design that left out either gate would later retire a phantom result, or would corrupt a rename register that another instruction owns. The bench fills the buffer so that the tail wraps past the head, then tries a dispatch while the buffer is full. A design that confused full with empty would overwrite the oldest entry. It requests a rollback in the same cycle as a ready retirement, and it names both an empty slot and the head entry. These cases expose a design that retires during a flush, that moves the tail for a rollback that should be ignored, or that computes the surviving count wrongly across the wrap.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned DEF_DEPTH  = 8;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_AREG_W = 5;
  localparam int unsigned DEF_PREG_W = 6;
  localparam int unsigned DEF_DATA_W = 32;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] flush_idx_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  logic [IDX_W:0]   head_q, tail_q, count;
  logic [IDX_W-1:0] keep_w;

  assign count  = tail_q - head_q;
  assign full_o = (count == (IDX_W+1)'(DEPTH));
  assign head_o = head_q[IDX_W-1:0];
  assign tail_o = tail_q[IDX_W-1:0];
  // survivors = ring distance from head to the first discarded entry
  assign keep_w = flush_idx_i - head_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (flush_i)      tail_q <= head_q + {1'b0, keep_w};
      else if (alloc_i) tail_q <= tail_q + 1'b1;
      if (retire_i && !flush_i) head_q <= head_q + 1'b1;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= (IDX_W+1)'(DEPTH));
  p_alloc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !flush_i) |=> (tail_q == $past(tail_q) + 1'b1));
  p_flush_tail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tail_o == $past(flush_idx_i)));
  p_flush_holds_head_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (head_q == $past(head_q)));
  p_single_retire_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> ((head_q - $past(head_q)) <= (IDX_W+1)'(1)));
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned AREG_W = 5,
  parameter int unsigned PREG_W = 6,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [ADDR_W-1:0] alloc_pc_i,
  input  logic [AREG_W-1:0] alloc_areg_i,
  input  logic [PREG_W-1:0] alloc_preg_i,
  input  logic              iss_i,
  input  logic [IDX_W-1:0]  iss_idx_i,
  input  logic              cmp_i,
  input  logic [IDX_W-1:0]  cmp_idx_i,
  input  logic              ret_i,
  input  logic [IDX_W-1:0]  head_idx_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_idx_i,
  output logic [DEPTH-1:0]  valid_o,
  output logic              head_done_o,
  output logic [ADDR_W-1:0] head_pc_o,
  output logic [AREG_W-1:0] head_areg_o,
  output logic [PREG_W-1:0] head_preg_o,
  output logic              cmp_ok_o,
  output logic [PREG_W-1:0] cmp_preg_o
);
  logic [DEPTH-1:0]  valid_q, issued_q, done_q;
  logic [DEPTH-1:0]  alloc_hit, iss_hit, cmp_hit, ret_hit, kill;
  logic [ADDR_W-1:0] pc_q   [DEPTH];
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [PREG_W-1:0] preg_q [DEPTH];
  logic [IDX_W-1:0]  flush_age;

  assign flush_age = flush_idx_i - head_idx_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [IDX_W-1:0] MY = IDX_W'(g);
    logic [IDX_W-1:0] age;
    assign age          = MY - head_idx_i;
    assign alloc_hit[g] = alloc_i && (alloc_idx_i == MY);
    assign iss_hit[g]   = iss_i && (iss_idx_i == MY) && valid_q[g];
    assign cmp_hit[g]   = cmp_i && (cmp_idx_i == MY) && valid_q[g] && issued_q[g];
    assign ret_hit[g]   = ret_i && (head_idx_i == MY);
    assign kill[g]      = flush_i && valid_q[g] && (age >= flush_age);

    p_done_after_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q[g]) |-> issued_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      issued_q <= '0;
      done_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i] || ret_hit[i]) begin
          valid_q[i]  <= 1'b0;
          issued_q[i] <= 1'b0;
          done_q[i]   <= 1'b0;
        end else if (alloc_hit[i]) begin
          valid_q[i]  <= 1'b1;
          issued_q[i] <= 1'b0;
          done_q[i]   <= 1'b0;
        end else begin
          if (iss_hit[i]) issued_q[i] <= 1'b1;
          if (cmp_hit[i]) done_q[i]   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      pc_q[alloc_idx_i]   <= alloc_pc_i;
      areg_q[alloc_idx_i] <= alloc_areg_i;
      preg_q[alloc_idx_i] <= alloc_preg_i;
    end
  end

  assign valid_o     = valid_q;
  assign head_done_o = valid_q[head_idx_i] && done_q[head_idx_i];
  assign head_pc_o   = pc_q[head_idx_i];
  assign head_areg_o = areg_q[head_idx_i];
  assign head_preg_o = preg_q[head_idx_i];
  assign cmp_ok_o    = |cmp_hit;
  assign cmp_preg_o  = preg_q[cmp_idx_i];
endmodule

// File: rtl/rob_value_file.sv
module rob_value_file #(
  parameter int unsigned PREG_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NREG  = 1 << PREG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PREG_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PREG_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [PREG_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o
);
  logic [DATA_W-1:0] vals_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) vals_q[i] <= '0;
    end else if (we_i) begin
      vals_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_data_o = vals_q[ra_addr_i];
  assign rb_data_o = vals_q[rb_addr_i];
endmodule

// File: rtl/rob_retire_unit.sv
module rob_retire_unit
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned AREG_W = DEF_AREG_W,
  parameter int unsigned PREG_W = DEF_PREG_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [ADDR_W-1:0] disp_pc_i,
  input  logic [AREG_W-1:0] disp_areg_i,
  input  logic [PREG_W-1:0] disp_preg_i,
  output logic              disp_ready_o,
  output logic [IDX_W-1:0]  disp_idx_o,
  input  logic              iss_valid_i,
  input  logic [IDX_W-1:0]  iss_idx_i,
  input  logic              cmp_valid_i,
  input  logic [IDX_W-1:0]  cmp_idx_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic [PREG_W-1:0] rd_preg_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rb_valid_i,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic              ret_valid_o,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic [AREG_W-1:0] ret_areg_o,
  output logic [DATA_W-1:0] ret_data_o
);
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full, alloc, retire, flush;
  logic [DEPTH-1:0]  valid;
  logic              head_done, cmp_ok;
  logic [PREG_W-1:0] head_preg, cmp_preg;

  assign disp_ready_o = !full && !rb_valid_i;
  assign alloc        = disp_valid_i && disp_ready_o;
  assign flush        = rb_valid_i && valid[rb_idx_i];
  assign retire       = head_done && !rb_valid_i;
  assign disp_idx_o   = tail_idx;
  assign ret_valid_o  = retire;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .retire_i    (retire),
    .flush_i     (flush),
    .flush_idx_i (rb_idx_i),
    .head_o      (head_idx),
    .tail_o      (tail_idx),
    .full_o      (full)
  );

  rob_entry_array #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) u_ent (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_idx_i  (tail_idx),
    .alloc_pc_i   (disp_pc_i),
    .alloc_areg_i (disp_areg_i),
    .alloc_preg_i (disp_preg_i),
    .iss_i        (iss_valid_i),
    .iss_idx_i    (iss_idx_i),
    .cmp_i        (cmp_valid_i && !flush),
    .cmp_idx_i    (cmp_idx_i),
    .ret_i        (retire),
    .head_idx_i   (head_idx),
    .flush_i      (flush),
    .flush_idx_i  (rb_idx_i),
    .valid_o      (valid),
    .head_done_o  (head_done),
    .head_pc_o    (ret_pc_o),
    .head_areg_o  (ret_areg_o),
    .head_preg_o  (head_preg),
    .cmp_ok_o     (cmp_ok),
    .cmp_preg_o   (cmp_preg)
  );

  rob_value_file #(.PREG_W(PREG_W), .DATA_W(DATA_W)) u_val (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cmp_ok),
    .waddr_i   (cmp_preg),
    .wdata_i   (cmp_data_i),
    .ra_addr_i (head_preg),
    .ra_data_o (ret_data_o),
    .rb_addr_i (rd_preg_i),
    .rb_data_o (rd_data_o)
  );

  p_ret_needs_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> valid[head_idx]);
  p_full_no_alloc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && disp_valid_i) |=> ($past(tail_idx) == tail_idx || $past(flush)));
endmodule

// File: tb/sim_rob_retire_unit.sv
`timescale 1ns/1ps
module sim_rob_retire_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        disp_valid = 0;
  logic [31:0] disp_pc = 0;
  logic [4:0]  disp_areg = 0;
  logic [5:0]  disp_preg = 0;
  logic        disp_ready;
  logic [2:0]  disp_idx;
  logic        iss_valid = 0;
  logic [2:0]  iss_idx = 0;
  logic        cmp_valid = 0;
  logic [2:0]  cmp_idx = 0;
  logic [31:0] cmp_data = 0;
  logic [5:0]  rd_preg = 0;
  logic [31:0] rd_data;
  logic        rb_valid = 0;
  logic [2:0]  rb_idx = 0;
  logic        ret_valid;
  logic [31:0] ret_pc;
  logic [4:0]  ret_areg;
  logic [31:0] ret_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  rob_retire_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_pc_i(disp_pc), .disp_areg_i(disp_areg),
    .disp_preg_i(disp_preg), .disp_ready_o(disp_ready), .disp_idx_o(disp_idx),
    .iss_valid_i(iss_valid), .iss_idx_i(iss_idx),
    .cmp_valid_i(cmp_valid), .cmp_idx_i(cmp_idx), .cmp_data_i(cmp_data),
    .rd_preg_i(rd_preg), .rd_data_o(rd_data),
    .rb_valid_i(rb_valid), .rb_idx_i(rb_idx),
    .ret_valid_o(ret_valid), .ret_pc_o(ret_pc), .ret_areg_o(ret_areg),
    .ret_data_o(ret_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic disp(input logic [31:0] pc, input logic [4:0] ar, input logic [5:0] pr);
    disp_valid = 1; disp_pc = pc; disp_areg = ar; disp_preg = pr;
    @(negedge clk);
    disp_valid = 0;
  endtask

  task automatic issue(input logic [2:0] idx);
    iss_valid = 1; iss_idx = idx;
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic complete(input logic [2:0] idx, input logic [31:0] d);
    cmp_valid = 1; cmp_idx = idx; cmp_data = d;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic expect_ret(input string req, input logic [31:0] pc, input logic [4:0] ar,
                            input logic [31:0] d);
    #1;
    chk(req, {31'b0, ret_valid}, 32'd1);
    chk(req, ret_pc, pc);
    chk(req, {27'b0, ret_areg}, {27'b0, ar});
    chk(req, ret_data, d);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready", {31'b0, disp_ready}, 32'd1);
    chk("R1 idx", {29'b0, disp_idx}, 32'd0);
    chk("R1 ret", {31'b0, ret_valid}, 32'd0);
  endtask

  // out-of-order completion, in-order retirement, bypass read
  task automatic t_order();
    for (int k = 0; k < 3; k++) begin
      #1 chk("R2 idx", {29'b0, disp_idx}, k);
      disp(32'h100 + 4*k, 5'(3 + 2*k), 6'(10 + k));
    end
    for (int k = 0; k < 3; k++) issue(3'(k));
    complete(3'd2, 32'hCC);
    #1 chk("R4 young done waits", {31'b0, ret_valid}, 32'd0);
    rd_preg = 6'd12;
    #1 chk("R7 bypass", rd_data, 32'hCC);
    complete(3'd1, 32'hBB);
    #1 chk("R4 still waits", {31'b0, ret_valid}, 32'd0);
    complete(3'd0, 32'hAA);
    expect_ret("R5 ret A", 32'h100, 5'd3, 32'hAA);
    @(negedge clk);
    expect_ret("R11 ret B", 32'h104, 5'd5, 32'hBB);
    @(negedge clk);
    expect_ret("R11 ret C", 32'h108, 5'd7, 32'hCC);
    @(negedge clk);
    #1 chk("R11 drained", {31'b0, ret_valid}, 32'd0);
    chk("R2 idx after drain", {29'b0, disp_idx}, 32'd3);
  endtask

  // completion of a non-issued entry is ignored
  task automatic t_no_issue();
    disp(32'h200, 5'd1, 6'd20);
    complete(3'd3, 32'h11);
    #1 chk("R6 no done", {31'b0, ret_valid}, 32'd0);
    rd_preg = 6'd20;
    #1 chk("R6 no write", rd_data, 32'h0);
    issue(3'd3);
    complete(3'd3, 32'h22);
    expect_ret("R6 ret after issue", 32'h200, 5'd1, 32'h22);
    @(negedge clk);
  endtask

  // fill with wrap, blocked dispatch, rollback during ready retirement
  task automatic t_full_rollback();
    for (int k = 0; k < 8; k++) begin
      int idx = (4 + k) % 8;
      #1 chk("R2 wrap idx", {29'b0, disp_idx}, idx);
      disp(32'h1000 + idx, 5'(idx), 6'(32 + idx));
    end
    #1 chk("R3 full", {31'b0, disp_ready}, 32'd0);
    disp(32'hDEAD, 5'd31, 6'd63);
    issue(3'd4);
    issue(3'd6);
    complete(3'd4, 32'h44);
    rb_valid = 1; rb_idx = 3'd6;
    #1 chk("R9 no retire", {31'b0, ret_valid}, 32'd0);
    chk("R9 no dispatch", {31'b0, disp_ready}, 32'd0);
    @(negedge clk);
    rb_valid = 0;
    expect_ret("R3 R9 head kept", 32'h1004, 5'd4, 32'h44);
    chk("R8 tail", {29'b0, disp_idx}, 32'd6);
    @(negedge clk);
    #1 chk("R4 head 5 not done", {31'b0, ret_valid}, 32'd0);
    complete(3'd6, 32'h66);
    rd_preg = 6'd38;
    #1 chk("R8 flushed cmp ignored", rd_data, 32'h0);
    disp(32'h2000, 5'd9, 6'd50);
    chk("R8 realloc", {29'b0, disp_idx}, 32'd7);
    issue(3'd5);
    issue(3'd6);
    complete(3'd6, 32'h77);
    complete(3'd5, 32'h55);
    expect_ret("R8 ret 5", 32'h1005, 5'd5, 32'h55);
    @(negedge clk);
    expect_ret("R8 ret new 6", 32'h2000, 5'd9, 32'h77);
    @(negedge clk);
    #1 chk("R8 empty", {31'b0, ret_valid}, 32'd0);
  endtask

  // rollback to invalid slot ignored; rollback to head empties
  task automatic t_rb_edges();
    disp(32'h3000, 5'd2, 6'd40);
    rb_valid = 1; rb_idx = 3'd2;
    @(negedge clk);
    rb_valid = 0;
    #1 chk("R10 tail unchanged", {29'b0, disp_idx}, 32'd0);
    rb_valid = 1; rb_idx = 3'd7;
    @(negedge clk);
    rb_valid = 0;
    #1 chk("R8 rollback head", {29'b0, disp_idx}, 32'd7);
    issue(3'd7);
    complete(3'd7, 32'h99);
    #1 chk("R8 nothing retires", {31'b0, ret_valid}, 32'd0);
    chk("R8 ready", {31'b0, disp_ready}, 32'd1);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_no_issue();
    t_full_rollback();
    t_rb_edges();
    report();
  end
endmodule